// File: doc/BRIEF.md
# Two-Input Pulse-Steered Up/Down Counter

This block is a binary counter whose direction is chosen by which of two count inputs receives a pulse. Both count inputs idle high. A low-then-high pulse on the up input adds one to the count. The same pulse on the down input subtracts one. The count advances on the rising edge of the pulse.

Both inputs are sampled on a free-running system clock. A registered copy of each input is used to find the rising edges, so the count inputs may be slow, asynchronous strobes.

An active-high clear and an active-low parallel load override counting. Two active-low terminal flags let several blocks be chained with no extra gates:
- The carry flag drops during the low half of an up pulse when the count is at its maximum.
- The borrow flag drops during the low half of a down pulse when the count is zero.

Run continuously on the up input, each count bit runs at half the rate of the bit below it, so the block also serves as a binary frequency divider.

Top module: `updn_pulse_counter`

## Requirements
- R1: A synchronous high `rst` sets `q` to 0 and drives `carry_n` and `borrow_n` high. Both count inputs are then treated as sampled high.
- R2: When `up_pulse` is sampled high on a clock edge after being sampled low on the previous edge, `q` rises by one at that same edge. This happens only if neither clear nor load is active and the down input shows no rising edge at the same time.
- R3: A rising edge on `dn_pulse` under the same conditions lowers `q` by one at that edge.
- R4: Counting up from the maximum value (all ones) gives 0. Counting down from 0 gives the maximum value.
- R5: `carry_n` is low exactly while the last sample of `up_pulse` is low and `q` equals the maximum value. The maximum for a 4-bit count is 15.
- R6: `borrow_n` is low exactly while the last sample of `dn_pulse` is low and `q` equals 0.
- R7: `clr` high sampled on an edge forces `q` to 0 at that edge, regardless of `load_n`, `din` or count edges.
- R8: `load_n` low with `clr` low copies `din` into `q` at the edge, regardless of count edges.
- R9: Rising edges on both count inputs at the same sampling edge leave `q` unchanged.
- R10: A count input held at a constant level produces no further counts.
- R11: Over 2^(WIDTH+1) consecutive up pulses starting from 0, bit i of `q` toggles 2^(WIDTH+1-i) times. Each bit toggles at half the rate of the bit below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| up_pulse | input | 1 | Up count strobe; idles high, counts on its rising edge |
| dn_pulse | input | 1 | Down count strobe; idles high, counts on its rising edge |
| clr | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low parallel load of `din` |
| din | input | WIDTH | Preset value for load |
| q | output | WIDTH | Count value, bit 0 least significant |
| carry_n | output | 1 | Active-low terminal-count flag for up counting |
| borrow_n | output | 1 | Active-low terminal-count flag for down counting |

## Verification
The bench builds the block with the default WIDTH of 4. This keeps the maximum value at 15, so both wrap points and both terminal flags are reached within a few dozen cycles. It also makes a full divider run of 32 up pulses short enough to count every toggle on all four bits. A fixed vector table covers the following:
- counting in both directions;
- loads near the wrap points;
- the clear-over-load and load-over-count priorities;
- simultaneous edges;
- inputs held high.

Directed steps then cover a mid-run reset and the divider ratios.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_INC   = 3'd1,
    ACT_DEC   = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_CLEAR = 3'd4
  } count_act_e;
endpackage

// File: rtl/updn_edge_sense.sv
module updn_edge_sense #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] prev,
  output logic [NCH-1:0] rise
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= 1'b1;
      else     prev[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic             up_rise,
  input  logic             dn_rise,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  count_act_e act;

  always_comb begin
    if (clr)                   act = ACT_CLEAR;
    else if (!load_n)          act = ACT_LOAD;
    else if (up_rise && !dn_rise) act = ACT_INC;
    else if (dn_rise && !up_rise) act = ACT_DEC;
    else                       act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      unique case (act)
        ACT_CLEAR: q <= '0;
        ACT_LOAD:  q <= din;
        ACT_INC:   q <= q + ONE;
        ACT_DEC:   q <= q - ONE;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/updn_flags.sv
module updn_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_prev,
  input  logic             dn_prev,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n  = ~(~up_prev & (q == TOP));
  assign borrow_n = ~(~dn_prev & (q == '0));
endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_pulse,
  input  logic             dn_pulse,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int NCH = 2;
  localparam int UP  = 0;
  localparam int DN  = 1;

  logic [NCH-1:0] prev, rise;

  updn_edge_sense #(.NCH(NCH)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({dn_pulse, up_pulse}),
    .prev (prev),
    .rise (rise)
  );

  updn_count_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .load_n  (load_n),
    .up_rise (rise[UP]),
    .dn_rise (rise[DN]),
    .din     (din),
    .q       (q)
  );

  updn_flags #(.WIDTH(WIDTH)) u_flags (
    .q        (q),
    .up_prev  (prev[UP]),
    .dn_prev  (prev[DN]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );
endmodule

// File: rtl/updn_pulse_counter_chk.sv
module updn_pulse_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             up_pulse,
  input logic             dn_pulse,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic u_s, d_s;
  always_ff @(posedge clk) begin
    if (rst) begin
      u_s <= 1'b1;
      d_s <= 1'b1;
    end else begin
      u_s <= up_pulse;
      d_s <= dn_pulse;
    end
  end

  logic u_e, d_e, free;
  assign u_e  = up_pulse & ~u_s;
  assign d_e  = dn_pulse & ~d_s;
  assign free = ~clr & load_n;

  // R1
  a_r1_reset: assert property (@(posedge clk) rst |=> (q == '0) && carry_n && borrow_n);

  a_r2_up: assert property (@(posedge clk) disable iff (rst)
    (free && u_e && !d_e) |=> q == WIDTH'($past(q) + 1'b1));

  a_r3_down: assert property (@(posedge clk) disable iff (rst)
    (free && d_e && !u_e) |=> q == WIDTH'($past(q) - 1'b1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (free && u_e && !d_e && q == TOP) |=> q == '0);

  a_r5_carry: assert property (@(posedge clk) disable iff (rst)
    carry_n == !(!u_s && q == TOP));

  a_r6_borrow: assert property (@(posedge clk) disable iff (rst)
    borrow_n == !(!d_s && q == '0));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);

  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> q == $past(din));

  a_r9_both: assert property (@(posedge clk) disable iff (rst)
    (free && u_e && d_e) |=> $stable(q));

  a_r10_level: assert property (@(posedge clk) disable iff (rst)
    (free && !u_e && !d_e) |=> $stable(q));
endmodule

bind updn_pulse_counter updn_pulse_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_updn_pulse_counter.sv
module tb_updn_pulse_counter;
  localparam int WIDTH = 4;
  localparam int NV    = 23;
  // {clr, load_n, up, dn, din[4], exp_q[4], exp_carry_n, exp_borrow_n}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd0, 1'b1,1'b1}, // idle low up
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd1, 1'b1,1'b1}, // R2 up edge
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd1, 1'b1,1'b1},
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd2, 1'b1,1'b1}, // R2
    {1'b0,1'b0,1'b1,1'b1,4'd14,4'd14,1'b1,1'b1}, // R8 load
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd14,1'b1,1'b1},
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd15,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd15,1'b0,1'b1}, // R5 carry low
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd0, 1'b1,1'b1}, // R4 up wrap
    {1'b0,1'b1,1'b1,1'b0,4'd0, 4'd0, 1'b1,1'b0}, // R6 borrow low
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd15,1'b1,1'b1}, // R4 down wrap, R3
    {1'b0,1'b1,1'b1,1'b0,4'd0, 4'd15,1'b1,1'b1},
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd14,1'b1,1'b1}, // R3
    {1'b0,1'b1,1'b0,1'b0,4'd0, 4'd14,1'b1,1'b1},
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd14,1'b1,1'b1}, // R9 both edges
    {1'b1,1'b0,1'b1,1'b1,4'd5, 4'd0, 1'b1,1'b1}, // R7 clear over load
    {1'b0,1'b0,1'b1,1'b1,4'd9, 4'd9, 1'b1,1'b1}, // R8
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd9, 1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b1,4'd3, 4'd3, 1'b1,1'b1}, // R8 load over count
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd3, 1'b1,1'b1}, // R10 held high
    {1'b0,1'b1,1'b1,1'b1,4'd0, 4'd3, 1'b1,1'b1}, // R10
    {1'b0,1'b1,1'b0,1'b1,4'd0, 4'd3, 1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,4'd0, 4'd0, 1'b1,1'b1}  // R7 clear over count
  };

  logic clk = 1'b0;
  logic rst, up_pulse, dn_pulse, clr, load_n;
  logic [WIDTH-1:0] din, q;
  logic carry_n, borrow_n;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  updn_pulse_counter #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .clr(clr), .load_n(load_n), .din(din), .q(q),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic ld, input logic u,
                      input logic d, input logic [WIDTH-1:0] v);
    @(negedge clk);
    clr = c; load_n = ld; up_pulse = u; dn_pulse = d; din = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; up_pulse = 1'b1; dn_pulse = 1'b1; clr = 1'b0; load_n = 1'b1; din = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 q", int'(q), 0);
    check("R1 carry_n", int'(carry_n), 1);
    check("R1 borrow_n", int'(borrow_n), 1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:6]);
      check($sformatf("vec%0d q", i), int'(q), int'(VEC[i][5:2]));
      check($sformatf("vec%0d carry_n R5", i), int'(carry_n), int'(VEC[i][1]));
      check($sformatf("vec%0d borrow_n R6", i), int'(borrow_n), int'(VEC[i][0]));
    end

    // R1: reset in mid-run, with a low up sample pending
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'd7);
    check("R8 preload", int'(q), 7);
    @(negedge clk);
    rst = 1'b1; up_pulse = 1'b0; load_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid q", int'(q), 0);
    check("R1 mid carry_n", int'(carry_n), 1);
    @(negedge clk);
    rst = 1'b0; up_pulse = 1'b1;

    // R11: divider ratios over 32 up pulses from zero
    begin
      int tog [WIDTH];
      logic [WIDTH-1:0] last;
      for (int b = 0; b < WIDTH; b++) tog[b] = 0;
      last = q;
      for (int n = 0; n < 2 ** (WIDTH + 1); n++) begin
        step(1'b0, 1'b1, 1'b0, 1'b1, '0);
        step(1'b0, 1'b1, 1'b1, 1'b1, '0);
        for (int b = 0; b < WIDTH; b++) if (q[b] != last[b]) tog[b]++;
        last = q;
      end
      for (int b = 0; b < WIDTH; b++)
        check($sformatf("R11 bit%0d toggles", b), tog[b], 2 ** (WIDTH + 1 - b));
      check("R11 end q", int'(q), 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule